// File: doc/BRIEF.md
# I2C Master Command Sequencer

This block sits between a queue of software command words and a byte-level I2C engine. Each command word names one byte: a write carries the data, a read asks for one byte back. From each word's flags and the direction of the word before it, the sequencer decides whether the byte needs a fresh START, a repeated START, a full address phase or none of these. It also decides whether a STOP follows the byte. It issues each bus operation to the byte engine over a request/acknowledge handshake and pushes the received bytes into a receive queue.

The target register selects the slave. It can select a 7-bit or 10-bit address, a general-call broadcast, or a START-byte preamble. The sequencer enforces the rules that apply when repeated STARTs are disabled. Every failed transfer is recorded as one bit in a sticky abort cause vector. While any cause is pending, the command queue is flushed and refuses new words. Software can also request an abort. The request ends the transfer with a STOP and clears itself when that STOP has completed.

Top module: `i2c_cmd_seq`

## Requirements
- R1: After reset the target register reads 0x055, the cause vector is zero, both queues are empty, the bus is not held and no engine request is raised.
- R2: A command word holds data in bits 7:0, read in bit 8 (1 = read), stop in bit 9 and forced restart in bit 10. Engine operation codes are 1 START, 2 RESTART, 3 STOP, 4 WRITE, 5 READ. A 7-bit write with stop on an idle bus produces START, WRITE {addr[6:0],0}, WRITE data, STOP.
- R3: While the bus is held, a command whose direction differs from the previous command gets RESTART and a new address byte. The address byte's bit 0 is 1 for a read. A command with the same direction gets only its data operation.
- R4: A set forced-restart flag produces RESTART and an address phase even when the direction does not change.
- R5: A set stop flag issues STOP after its byte even when more words are queued. The next queued word then starts with a fresh START.
- R6: When the queue runs empty after a word without stop, no STOP is issued, bus_held stays 1 and the next word continues the transfer.
- R7: Each read word produces exactly one READ operation and one receive-queue entry. The READ is marked to NACK (phy_rd_nack = 1) when its stop flag is set.
- R8: The target register holds the address in bits 9:0, the general-call/START-byte select in bit 10 (1 = START byte), the special-command enable in bit 11 and 10-bit mode in bit 12. Writes to it are ignored while enable is 1.
- R9: In 10-bit mode the address phase is {11110,a[9:8],0} followed by a[7:0]. A read then adds RESTART and {11110,a[9:8],1}.
- R10: In general-call mode the address byte is 0x00. A read word sets cause bit 4 and issues no bus operation.
- R11: In START-byte mode each fresh START is followed by WRITE 0x01, which must be NACKed, then RESTART and the normal address. If 0x01 is acknowledged, cause bit 7 is set. If restart support is off, cause bit 9 is set and nothing is issued.
- R12: With restart support off, a 10-bit read on an idle bus sets cause bit 10 with no bus operation. A direction change or forced restart while the bus is held sets cause bit 8 and issues STOP.
- R13: A NACK sets a cause bit: bit 0 for the 7-bit address, bits 1 and 2 for the first and second 10-bit address bytes, bit 3 for data, bit 5 for general call. STOP follows. Lost arbitration sets bit 12 with no STOP. The vector is sticky until abrt_clr, and while it is nonzero the command queue is flushed and drops pushes.
- R14: abort_req is accepted only while enable is 1. It sets abort_busy and cause bit 16 and issues STOP if the bus is held. abort_busy clears once the STOP completes, or at once if the bus was not held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Controller enable |
| restart_en | input | 1 | Repeated START support |
| tar_wr | input | 1 | Target register write strobe |
| tar_wdata | input | 13 | Target register write value |
| tar_q | output | 13 | Target register contents |
| cmd_push | input | 1 | Push a command word |
| cmd_word | input | 11 | Command word |
| cmd_empty | output | 1 | Command queue empty |
| cmd_full | output | 1 | Command queue full |
| rx_pop | input | 1 | Pop the receive queue |
| rx_data | output | 8 | Receive queue head |
| rx_empty | output | 1 | Receive queue empty |
| abort_req | input | 1 | Software abort request |
| abort_busy | output | 1 | Abort pending |
| abrt_clr | input | 1 | Clear the cause vector |
| abrt_cause | output | 17 | Sticky abort causes |
| bus_held | output | 1 | Transfer open (START issued, no STOP yet) |
| phy_req | output | 1 | Engine operation request |
| phy_op | output | 3 | Engine operation code |
| phy_wdata | output | 8 | Byte to transmit |
| phy_rd_nack | output | 1 | Master NACKs this READ |
| phy_ack | input | 1 | Engine done, one-cycle pulse |
| phy_nack | input | 1 | Slave NACKed the byte, valid with phy_ack |
| phy_arb_lost | input | 1 | Arbitration lost, valid with phy_ack |
| phy_rdata | input | 8 | Received byte, valid with phy_ack |

## Verification
The hardest situation to reach is the START-byte path. It needs a NACK on exactly the 0x01 byte and an acknowledge on every other byte, and the acknowledged variant has to abort. The bench's engine model takes a programmable operation index at which to answer NACK or report lost arbitration. This lets one run steer the sequencer into each abort branch, and also into held-bus states between separately pushed words.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
   localparam int CMD_W   = 11;
   localparam int TAR_W   = 13;
   localparam int CAUSE_W = 17;

   typedef enum logic [2:0] {
      OP_NONE    = 3'd0,
      OP_START   = 3'd1,
      OP_RESTART = 3'd2,
      OP_STOP    = 3'd3,
      OP_WRITE   = 3'd4,
      OP_READ    = 3'd5
   } phy_op_e;

   typedef enum logic [1:0] {
      SEL_FIRST,
      SEL_LOW,
      SEL_HDR_RD,
      SEL_SBYTE
   } addr_sel_e;

   // abort cause bit positions
   localparam int CB_A7_NACK   = 0;
   localparam int CB_A10_NACK1 = 1;
   localparam int CB_A10_NACK2 = 2;
   localparam int CB_DATA_NACK = 3;
   localparam int CB_GC_READ   = 4;
   localparam int CB_GC_NACK   = 5;
   localparam int CB_SB_ACKED  = 7;
   localparam int CB_NORS_DIR  = 8;
   localparam int CB_NORS_SB   = 9;
   localparam int CB_NORS_10RD = 10;
   localparam int CB_ARB_LOST  = 12;
   localparam int CB_USER      = 16;
endpackage

// File: rtl/i2c_seq_fifo.sv
module i2c_seq_fifo #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             push,
   input  logic [WIDTH-1:0] wdata,
   input  logic             pop,
   output logic [WIDTH-1:0] rdata,
   output logic             empty,
   output logic             full
);
   localparam int AW = $clog2(DEPTH);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("i2c_seq_fifo: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wp, rp;
   logic [AW:0]      cnt;
   logic             do_push, do_pop;

   assign do_push = push && !full && !flush;
   assign do_pop  = pop && !empty && !flush;
   assign empty   = (cnt == '0);
   assign full    = (cnt == (AW+1)'(DEPTH));
   assign rdata   = mem[rp];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else if (flush) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
         if (do_push && !do_pop)      cnt <= cnt + 1'b1;
         else if (do_pop && !do_push) cnt <= cnt - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= wdata;
   end
endmodule

// File: rtl/i2c_seq_addr_gen.sv
module i2c_seq_addr_gen
   import i2c_seq_pkg::*;
(
   input  logic [TAR_W-1:0] tar,
   input  logic             dir,
   input  addr_sel_e        sel,
   output logic [7:0]       abyte
);
   logic gc_mode, ten_bit;

   assign gc_mode = tar[11] && !tar[10];
   assign ten_bit = tar[12];

   always_comb begin
      case (sel)
         SEL_LOW:    abyte = tar[7:0];
         SEL_HDR_RD: abyte = {5'b11110, tar[9:8], 1'b1};
         SEL_SBYTE:  abyte = 8'h01;
         default: begin
            if (gc_mode)      abyte = 8'h00;
            else if (ten_bit) abyte = {5'b11110, tar[9:8], 1'b0};
            else              abyte = {tar[6:0], dir};
         end
      endcase
   end
endmodule

// File: rtl/i2c_cmd_seq.sv
module i2c_cmd_seq
   import i2c_seq_pkg::*;
#(
   parameter int              CMD_DEPTH = 16,
   parameter int              RX_DEPTH  = 16,
   parameter logic [12:0]     TAR_RESET = 13'h055
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               enable,
   input  logic               restart_en,
   input  logic               tar_wr,
   input  logic [12:0]        tar_wdata,
   output logic [12:0]        tar_q,
   input  logic               cmd_push,
   input  logic [10:0]        cmd_word,
   output logic               cmd_empty,
   output logic               cmd_full,
   input  logic               rx_pop,
   output logic [7:0]         rx_data,
   output logic               rx_empty,
   input  logic               abort_req,
   output logic               abort_busy,
   input  logic               abrt_clr,
   output logic [16:0]        abrt_cause,
   output logic               bus_held,
   output logic               phy_req,
   output logic [2:0]         phy_op,
   output logic [7:0]         phy_wdata,
   output logic               phy_rd_nack,
   input  logic               phy_ack,
   input  logic               phy_nack,
   input  logic               phy_arb_lost,
   input  logic [7:0]         phy_rdata
);
   typedef enum logic [3:0] {
      S_IDLE, S_START, S_SBYTE, S_SBRS, S_ADDR1, S_ADDR2,
      S_RS10, S_ADDR3, S_DATA, S_STOP
   } seq_state_e;

   generate
      if (CMD_DEPTH > 256 || RX_DEPTH > 256) begin : g_bad_depth
         $error("i2c_cmd_seq: queue depth above 256 not supported");
      end
   endgenerate

   seq_state_e             state;
   logic [9:0]             cur;
   logic                   fresh, held, prev_dir, abort_pend;
   logic [CAUSE_W-1:0]     cause;
   logic [TAR_W-1:0]       tar;
   logic [CMD_W-1:0]       head;
   logic                   cmd_pop, rx_push, rx_full, flush;
   logic                   cur_rd, cur_stop, gc_mode, sb_mode, ten_bit;
   logic                   h_rd, dir_chg;
   addr_sel_e              sel;
   logic [7:0]             abyte;
   phy_op_e                op;

   assign cur_rd   = cur[8];
   assign cur_stop = cur[9];
   assign gc_mode  = tar[11] && !tar[10];
   assign sb_mode  = tar[11] && tar[10];
   assign ten_bit  = tar[12];
   assign flush    = (cause != '0);
   assign h_rd     = head[8];
   assign dir_chg  = held && ((h_rd != prev_dir) || head[10]);
   assign cmd_pop  = (state == S_IDLE) && !abort_pend && enable && !cmd_empty && !flush;
   assign rx_push  = (state == S_DATA) && phy_ack && cur_rd && !phy_arb_lost;

   i2c_seq_fifo #(.WIDTH(CMD_W), .DEPTH(CMD_DEPTH)) u_cmd_q (
      .clk(clk), .rst_n(rst_n), .flush(flush), .push(cmd_push), .wdata(cmd_word),
      .pop(cmd_pop), .rdata(head), .empty(cmd_empty), .full(cmd_full));

   i2c_seq_fifo #(.WIDTH(8), .DEPTH(RX_DEPTH)) u_rx_q (
      .clk(clk), .rst_n(rst_n), .flush(1'b0), .push(rx_push), .wdata(phy_rdata),
      .pop(rx_pop), .rdata(rx_data), .empty(rx_empty), .full(rx_full));

   always_comb begin
      case (state)
         S_SBYTE: sel = SEL_SBYTE;
         S_ADDR2: sel = SEL_LOW;
         S_ADDR3: sel = SEL_HDR_RD;
         default: sel = SEL_FIRST;
      endcase
   end

   i2c_seq_addr_gen u_addr (.tar(tar), .dir(cur_rd), .sel(sel), .abyte(abyte));

   always_comb begin
      case (state)
         S_START:         op = fresh ? OP_START : OP_RESTART;
         S_SBRS, S_RS10:  op = OP_RESTART;
         S_STOP:          op = OP_STOP;
         S_DATA:          op = cur_rd ? OP_READ : OP_WRITE;
         S_IDLE:          op = OP_NONE;
         default:         op = OP_WRITE;
      endcase
   end

   assign phy_op      = op;
   assign phy_req     = (state != S_IDLE) && !((state == S_DATA) && cur_rd && rx_full);
   assign phy_wdata   = (state == S_DATA) ? cur[7:0] : abyte;
   assign phy_rd_nack = (state == S_DATA) && cur_rd && cur_stop;
   assign tar_q       = tar;
   assign abrt_cause  = cause;
   assign abort_busy  = abort_pend;
   assign bus_held    = held;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tar <= TAR_RESET;
      else if (tar_wr && !enable) tar <= tar_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= S_IDLE;
         cur        <= '0;
         fresh      <= 1'b0;
         held       <= 1'b0;
         prev_dir   <= 1'b0;
         abort_pend <= 1'b0;
         cause      <= '0;
      end else begin
         if (abrt_clr) cause <= '0;
         if (abort_req && enable) abort_pend <= 1'b1;
         case (state)
            S_IDLE: begin
               if (abort_pend) begin
                  cause[CB_USER] <= 1'b1;
                  if (held) state <= S_STOP;
                  else      abort_pend <= 1'b0;
               end else if (cmd_pop) begin
                  cur <= head[9:0];
                  if (gc_mode && h_rd) begin
                     cause[CB_GC_READ] <= 1'b1;
                     if (held) state <= S_STOP;
                  end else if (!held && sb_mode && !restart_en) begin
                     cause[CB_NORS_SB] <= 1'b1;
                  end else if (!held && ten_bit && h_rd && !restart_en) begin
                     cause[CB_NORS_10RD] <= 1'b1;
                  end else if (dir_chg && !restart_en) begin
                     cause[CB_NORS_DIR] <= 1'b1;
                     state <= S_STOP;
                  end else if (!held || dir_chg) begin
                     fresh <= !held;
                     state <= S_START;
                  end else begin
                     state <= S_DATA;
                  end
               end
            end
            default: begin
               if (phy_ack) begin
                  if (phy_arb_lost) begin
                     cause[CB_ARB_LOST] <= 1'b1;
                     held  <= 1'b0;
                     state <= S_IDLE;
                  end else begin
                     case (state)
                        S_START: begin
                           held  <= 1'b1;
                           state <= (fresh && sb_mode) ? S_SBYTE : S_ADDR1;
                        end
                        S_SBYTE: begin
                           if (!phy_nack) begin
                              cause[CB_SB_ACKED] <= 1'b1;
                              state <= S_STOP;
                           end else state <= S_SBRS;
                        end
                        S_SBRS: state <= S_ADDR1;
                        S_ADDR1: begin
                           if (phy_nack) begin
                              if (gc_mode)      cause[CB_GC_NACK]   <= 1'b1;
                              else if (ten_bit) cause[CB_A10_NACK1] <= 1'b1;
                              else              cause[CB_A7_NACK]   <= 1'b1;
                              state <= S_STOP;
                           end else state <= (ten_bit && !gc_mode) ? S_ADDR2 : S_DATA;
                        end
                        S_ADDR2: begin
                           if (phy_nack) begin
                              cause[CB_A10_NACK2] <= 1'b1;
                              state <= S_STOP;
                           end else state <= cur_rd ? S_RS10 : S_DATA;
                        end
                        S_RS10: state <= S_ADDR3;
                        S_ADDR3: begin
                           if (phy_nack) begin
                              cause[CB_A10_NACK1] <= 1'b1;
                              state <= S_STOP;
                           end else state <= S_DATA;
                        end
                        S_DATA: begin
                           prev_dir <= cur_rd;
                           if (!cur_rd && phy_nack) begin
                              cause[CB_DATA_NACK] <= 1'b1;
                              state <= S_STOP;
                           end else state <= cur_stop ? S_STOP : S_IDLE;
                        end
                        default: begin
                           held       <= 1'b0;
                           abort_pend <= 1'b0;
                           state      <= S_IDLE;
                        end
                     endcase
                  end
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/i2c_cmd_seq_chk.sv
module i2c_cmd_seq_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        enable,
   input logic        tar_wr,
   input logic [12:0] tar_q,
   input logic        abort_busy,
   input logic        abrt_clr,
   input logic [16:0] abrt_cause,
   input logic        phy_req,
   input logic [2:0]  phy_op,
   input logic        phy_rd_nack,
   input logic        phy_ack
);
   // R2: a pending engine request holds its operation until acknowledged
   p_req_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (phy_req && !phy_ack) |=> (phy_req && $stable(phy_op)));

   // R7: the NACK marker only accompanies a READ
   p_rd_nack_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
      phy_rd_nack |-> (phy_op == 3'd5));

   // R8: target writes while enabled leave the register unchanged
   p_tar_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (tar_wr && enable) |=> $stable(tar_q));

   // R13: the cause vector stays set until cleared
   p_cause_sticky_r13: assert property (@(posedge clk) disable iff (!rst_n)
      ((abrt_cause != '0) && !abrt_clr) |=> (abrt_cause != '0));

   // R13: no fresh START while an abort cause is pending
   p_no_start_abort_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (abrt_cause != '0) |-> !(phy_req && phy_op == 3'd1));

   // R14: an abort request is not taken while disabled
   p_abort_en_r14: assert property (@(posedge clk) disable iff (!rst_n)
      (!enable && !abort_busy) |=> !abort_busy);
endmodule

bind i2c_cmd_seq i2c_cmd_seq_chk u_chk (.*);

// File: tb/tb_i2c_cmd_seq.sv
`timescale 1ns/1ps
module tb_i2c_cmd_seq;
   localparam int ST = 256, RS = 512, SP = 768;
   localparam int WRB = 1024, RDN = 1281, RDA = 1280;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b0, restart_en = 1'b1;
   logic        tar_wr = 1'b0;
   logic [12:0] tar_wdata = '0;
   logic [12:0] tar_q;
   logic        cmd_push = 1'b0;
   logic [10:0] cmd_word = '0;
   logic        cmd_empty, cmd_full;
   logic        rx_pop = 1'b0;
   logic [7:0]  rx_data;
   logic        rx_empty;
   logic        abort_req = 1'b0, abort_busy;
   logic        abrt_clr = 1'b0;
   logic [16:0] abrt_cause;
   logic        bus_held, phy_req, phy_rd_nack;
   logic [2:0]  phy_op;
   logic [7:0]  phy_wdata;
   logic        phy_ack = 1'b0, phy_nack = 1'b0, phy_arb_lost = 1'b0;
   logic [7:0]  phy_rdata = '0;

   int errors = 0, checks = 0;
   int log_q [64];
   int log_n = 0;
   int nack_at = -1, arb_at = -1;
   bit done = 0;

   always #4 clk = ~clk;

   i2c_cmd_seq dut (.*);

   // byte engine model: acknowledges each request after three cycles
   initial begin
      int cnt = 0;
      forever begin
         @(negedge clk);
         phy_ack = 1'b0; phy_nack = 1'b0; phy_arb_lost = 1'b0;
         if (phy_req) begin
            if (cnt == 2) begin
               if (log_n < 64) begin
                  if (phy_op == 3'd4)      log_q[log_n] = WRB + int'(phy_wdata);
                  else if (phy_op == 3'd5) log_q[log_n] = RDA + int'(phy_rd_nack);
                  else                     log_q[log_n] = int'(phy_op) * 256;
               end
               phy_ack      = 1'b1;
               phy_nack     = (log_n == nack_at);
               phy_arb_lost = (log_n == arb_at);
               phy_rdata    = 8'hC0 | 8'(log_n);
               log_n++;
               cnt = 0;
            end else cnt++;
         end else cnt = 0;
      end
   end

   task automatic check(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic expect_seq(string tag, int n, int e0 = -1, int e1 = -1, int e2 = -1,
                             int e3 = -1, int e4 = -1, int e5 = -1, int e6 = -1, int e7 = -1);
      int e [8];
      e = '{e0, e1, e2, e3, e4, e5, e6, e7};
      check({tag, " op count"}, log_n, n);
      for (int i = 0; i < n && i < 8; i++) check($sformatf("%s op %0d", tag, i), log_q[i], e[i]);
   endtask

   task automatic settle();
      int q = 0;
      while (q < 12) begin
         @(negedge clk);
         if (phy_req) q = 0; else q++;
      end
   endtask

   task automatic push(int w);
      @(negedge clk); cmd_push = 1'b1; cmd_word = 11'(w);
      @(negedge clk); cmd_push = 1'b0;
   endtask

   task automatic set_tar(int v);
      @(negedge clk); enable = 1'b0; tar_wr = 1'b1; tar_wdata = 13'(v);
      @(negedge clk); tar_wr = 1'b0; enable = 1'b1;
   endtask

   task automatic pop_rx(string tag, int exp);
      check({tag, " rx not empty"}, int'(rx_empty), 0);
      check({tag, " rx data"}, int'(rx_data), exp);
      @(negedge clk); rx_pop = 1'b1;
      @(negedge clk); rx_pop = 1'b0;
   endtask

   task automatic clear_cause();
      @(negedge clk); abrt_clr = 1'b1;
      @(negedge clk); abrt_clr = 1'b0;
   endtask

   task automatic new_log();
      log_n = 0; nack_at = -1; arb_at = -1;
   endtask

   task automatic t_reset();
      check("R1 tar reset", int'(tar_q), 'h055);
      check("R1 cause zero", int'(abrt_cause), 0);
      check("R1 cmd empty", int'(cmd_empty), 1);
      check("R1 rx empty", int'(rx_empty), 1);
      check("R1 no req", int'(phy_req), 0);
      check("R1 not held", int'(bus_held), 0);
   endtask

   task automatic t_basic_write();
      new_log(); push('h23C); settle();
      expect_seq("R2 write", 4, ST, WRB + 'hAA, WRB + 'h3C, SP);
   endtask

   task automatic t_dir_change();
      new_log(); push('h011); settle();
      check("R6 held no stop", log_n, 3);
      check("R6 bus_held", int'(bus_held), 1);
      push('h300); settle();
      expect_seq("R3 restart on dir change", 7, ST, WRB + 'hAA, WRB + 'h11, RS, WRB + 'hAB, RDN, SP);
      pop_rx("R7 read byte", 'hC5);
   endtask

   task automatic t_forced_restart();
      new_log(); push('h001); push('h602); settle();
      expect_seq("R4 forced restart", 7, ST, WRB + 'hAA, WRB + 'h01, RS, WRB + 'hAA, WRB + 'h02, SP);
   endtask

   task automatic t_stop_mid();
      new_log(); push('h210); push('h220); settle();
      expect_seq("R5 stop then start", 8, ST, WRB + 'hAA, WRB + 'h10, SP, ST, WRB + 'hAA, WRB + 'h20, SP);
   endtask

   task automatic t_reads();
      new_log(); push('h100); push('h300); settle();
      expect_seq("R7 two reads", 5, ST, WRB + 'hAB, RDA, RDN, SP);
      pop_rx("R7 first", 'hC2);
      pop_rx("R7 second", 'hC3);
      check("R7 rx drained", int'(rx_empty), 1);
   endtask

   task automatic t_tar();
      @(negedge clk); enable = 1'b1; tar_wr = 1'b1; tar_wdata = 13'h0123;
      @(negedge clk); tar_wr = 1'b0;
      check("R8 write ignored while enabled", int'(tar_q), 'h055);
      set_tar('h1ABC);
      check("R8 write while disabled", int'(tar_q), 'h1ABC);
   endtask

   task automatic t_ten_bit();
      set_tar('h12B5);
      new_log(); push('h23C); settle();
      expect_seq("R9 10-bit write", 5, ST, WRB + 'hF4, WRB + 'hB5, WRB + 'h3C, SP);
      new_log(); push('h300); settle();
      expect_seq("R9 10-bit read", 7, ST, WRB + 'hF4, WRB + 'hB5, RS, WRB + 'hF5, RDN, SP);
      pop_rx("R9 rx", 'hC5);
   endtask

   task automatic t_gen_call();
      set_tar('h800);
      new_log(); push('h277); settle();
      expect_seq("R10 general call write", 4, ST, WRB + 'h00, WRB + 'h77, SP);
      new_log(); push('h300); settle();
      check("R10 gc read cause", int'(abrt_cause), 'h10);
      check("R10 gc read no ops", log_n, 0);
      clear_cause();
   endtask

   task automatic t_start_byte();
      set_tar('hC55);
      new_log(); nack_at = 1; push('h266); settle();
      expect_seq("R11 start byte", 6, ST, WRB + 'h01, RS, WRB + 'hAA, WRB + 'h66, SP);
      new_log(); push('h266); settle();
      check("R11 start byte acked cause", int'(abrt_cause), 'h80);
      expect_seq("R11 acked ops", 3, ST, WRB + 'h01, SP);
      clear_cause();
      restart_en = 1'b0;
      new_log(); push('h266); settle();
      check("R11 no restart cause", int'(abrt_cause), 'h200);
      check("R11 no restart ops", log_n, 0);
      clear_cause();
   endtask

   task automatic t_no_restart();
      set_tar('h1055);
      new_log(); push('h300); settle();
      check("R12 10-bit read cause", int'(abrt_cause), 'h400);
      check("R12 10-bit read no ops", log_n, 0);
      clear_cause();
      set_tar('h055);
      new_log(); push('h005); push('h300); settle();
      check("R12 dir change cause", int'(abrt_cause), 'h100);
      expect_seq("R12 dir change ops", 4, ST, WRB + 'hAA, WRB + 'h05, SP);
      clear_cause();
      restart_en = 1'b1;
   endtask

   task automatic t_nacks();
      new_log(); nack_at = 1; push('h201); settle();
      check("R13 addr nack cause", int'(abrt_cause), 'h1);
      expect_seq("R13 addr nack ops", 3, ST, WRB + 'hAA, SP);
      new_log(); push('h201); settle();
      check("R13 push dropped while flushed", int'(cmd_empty), 1);
      check("R13 no ops while flushed", log_n, 0);
      clear_cause(); settle();
      check("R13 nothing after clear", log_n, 0);
      new_log(); nack_at = 2; push('h201); settle();
      check("R13 data nack cause", int'(abrt_cause), 'h8);
      clear_cause();
      new_log(); arb_at = 1; push('h201); settle();
      check("R13 arb lost cause", int'(abrt_cause), 'h1000);
      check("R13 arb lost no stop", log_n, 2);
      check("R13 arb lost releases bus", int'(bus_held), 0);
      clear_cause();
   endtask

   task automatic t_user_abort();
      @(negedge clk); enable = 1'b0; abort_req = 1'b1;
      @(negedge clk); abort_req = 1'b0;
      @(negedge clk);
      check("R14 abort ignored while disabled", int'(abort_busy), 0);
      enable = 1'b1;
      new_log(); push('h011); settle();
      @(negedge clk); abort_req = 1'b1;
      @(negedge clk); abort_req = 1'b0;
      check("R14 abort busy", int'(abort_busy), 1);
      settle();
      expect_seq("R14 abort stop", 4, ST, WRB + 'hAA, WRB + 'h11, SP);
      check("R14 abort cause", int'(abrt_cause), 'h10000);
      check("R14 abort busy cleared", int'(abort_busy), 0);
      clear_cause();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      enable = 1'b1;
      t_basic_write();
      t_dir_change();
      t_forced_restart();
      t_stop_mid();
      t_reads();
      t_tar();
      t_ten_bit();
      t_gen_call();
      t_start_byte();
      t_no_restart();
      t_nacks();
      t_user_abort();
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule